// File: doc/BRIEF.md
# Glitch Detector Security Controller

This block is the software-facing control point for four external voltage and clock glitch detectors. Secure software reaches it over an APB slave port. Through this port it can force the detectors armed, or drop an arming that the fuse defaults requested. It can also replace each detector's factory sensitivity with its own value. A single write to a lock byte then freezes that configuration until the next reset.

The raw trigger lines from the detectors are asynchronous. The block passes them through a two-flop synchronizer and records each one in a sticky flag that software clears by writing 1. Software can also inject triggers. When the detectors are armed, any real or injected trigger raises a reset request for the switched power domain. The first cycle of each request also carries a one-cycle reset-reason pulse.

The control words act only on exact magic values, so a corrupted write tends to leave the block in the safe state. A sensitivity override also needs an inverted copy of every field to match that field.

Top module: `glitch_ctl`

## Requirements
- R1: After reset, the registers read as follows: force-arm word (offset 0x00) 0x5BAD, disarm word (0x04) 0, sensitivity word (0x08) 0, lock byte (0x0C) 0 and trigger flags (0x10) 0. After reset, `rst_req` is 0 and `armed` equals `otp_arm`.
- R2: The force-arm word holds 16 bits. `armed` is 1 whenever it holds any value other than 0x5BAD, whatever `otp_arm` and the disarm word are.
- R3: While the force-arm word is 0x5BAD, `armed` = `otp_arm` AND (disarm word != 0xDCAF). The disarm word holds 16 bits and has no effect while arming is forced.
- R4: The sensitivity word holds per-detector values in bits [7:0], with detector d at bits [2d+1:2d]. It holds their inverted copies in bits [15:8], with detector d at bits [2d+9:2d+8], and an override key in bits [31:24]. Bits [23:16] always read 0. When the key is not 0xDE, every `sens_eff` field equals its `otp_sens` field, which uses the same per-detector layout as bits [7:0].
- R5: With the key equal to 0xDE, detector d uses its register value only when its inverted copy equals the bitwise inverse of that value. Otherwise it uses its `otp_sens` field.
- R6: Once the lock byte (8 bits) is nonzero, writes to offsets 0x00, 0x04, 0x08 and 0x0C change nothing until reset. Writes to 0x10 and 0x14 still act.
- R7: Trigger flag d (bit d at 0x10) sets on the third rising clock edge after `det_raw[d]` goes high, following two synchronizer flops. It stays set until software clears it.
- R8: Writing 1 to a bit of the flags clears that bit. When a synchronized trigger and a clear hit the same bit in the same cycle, the bit stays set.
- R9: Writing ones to the trigger-inject register (0x14, bits [3:0]) sets the matching flags at the write's commit edge. That register always reads 0.
- R10: `rst_req` is registered. It is 1 in the cycle after one in which `armed` was 1 and a synchronized trigger or an inject write was present. It is 0 whenever the condition was false in the previous cycle.
- R11: `rst_reason` is high for exactly one cycle, the first cycle of each `rst_req` assertion.
- R12: An access with `psecure` low reads 0, changes no state and asserts `pslverr` in its access phase.
- R13: Reads of unmapped offsets return 0 without error. `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| psecure | input | 1 | Secure-access qualifier for the current transfer |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error on non-secure access |
| det_raw | input | 4 | Asynchronous raw detector trigger lines |
| otp_arm | input | 1 | Fuse default arming request |
| otp_sens | input | 8 | Fuse default sensitivities, 2 bits per detector |
| armed | output | 1 | Effective arm state |
| sens_eff | output | 8 | Effective sensitivities, 2 bits per detector |
| rst_req | output | 1 | Domain reset request |
| rst_reason | output | 1 | One-cycle glitch reset-reason pulse |

## Verification
The hardest case to reach from the ports is a clear that collides with a trigger still being asserted. The bench holds a detector line high until it has passed the synchronizer, then writes 1 to that flag bit and reads it back still set. The exact synchronizer latency is measured on `rst_req` with arming forced, at each falling edge after the raw line rises. The sensitivity override is swept over all 256 value bytes against four inverse patterns, with varying fuse defaults, so every detector sees both matching and mismatching copies.

// File: rtl/glitch_ctl_pkg.sv
package glitch_ctl_pkg;

    localparam int NUM_DET = 4;
    localparam int SENS_W  = 2;
    localparam int SV_W    = NUM_DET * SENS_W;
    localparam int DATA_W  = 32;

    localparam logic [15:0] ARM_KEEP   = 16'h5BAD;
    localparam logic [15:0] DISARM_KEY = 16'hDCAF;
    localparam logic [7:0]  OVR_KEY    = 8'hDE;

    localparam logic [31:0] OFS_ARM    = 32'h00;
    localparam logic [31:0] OFS_DISARM = 32'h04;
    localparam logic [31:0] OFS_SENS   = 32'h08;
    localparam logic [31:0] OFS_LOCK   = 32'h0C;
    localparam logic [31:0] OFS_STAT   = 32'h10;
    localparam logic [31:0] OFS_FORCE  = 32'h14;

    typedef struct packed {
        logic [7:0]      ovr;
        logic [SV_W-1:0] inv;
        logic [SV_W-1:0] val;
    } sens_cfg_t;

    typedef struct packed {
        logic [15:0] arm;
        logic [15:0] disarm;
        sens_cfg_t   sens;
        logic [7:0]  lock;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{arm: ARM_KEEP, disarm: 16'h0,
                                   sens: '{ovr: 8'h0, inv: '0, val: '0},
                                   lock: 8'h0};

    typedef enum logic [2:0] {
        SEL_NONE, SEL_ARM, SEL_DISARM, SEL_SENS, SEL_LOCK, SEL_STAT, SEL_FORCE
    } reg_sel_t;

    function automatic reg_sel_t decode_sel(input logic [31:0] a);
        case (a)
            OFS_ARM:    return SEL_ARM;
            OFS_DISARM: return SEL_DISARM;
            OFS_SENS:   return SEL_SENS;
            OFS_LOCK:   return SEL_LOCK;
            OFS_STAT:   return SEL_STAT;
            OFS_FORCE:  return SEL_FORCE;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/glitch_ctl_sync.sv
module glitch_ctl_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic stage1, stage2;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= async_in[i];
                stage2 <= stage1;
            end
        end
        assign sync_out[i] = stage2;
    end
endmodule

// File: rtl/glitch_ctl_regs.sv
module glitch_ctl_regs
    import glitch_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    input  logic               psecure,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_DET-1:0] det_sync,
    output cfg_t               cfg,
    output logic [NUM_DET-1:0] status,
    output logic [NUM_DET-1:0] force_vec
);
    logic               access, sec_ok, wr, cfg_wr;
    reg_sel_t           sel;
    logic [NUM_DET-1:0] clr_vec;
    logic               unused_bits;

    assign access  = psel & penable;
    assign sec_ok  = access & psecure;
    assign wr      = sec_ok & pwrite;
    assign cfg_wr  = wr & (cfg.lock == 8'h0);
    assign sel     = decode_sel(32'(paddr));
    assign pready  = 1'b1;
    assign pslverr = access & ~psecure;

    assign force_vec = (wr && sel == SEL_FORCE) ? pwdata[NUM_DET-1:0] : '0;
    assign clr_vec   = (wr && sel == SEL_STAT)  ? pwdata[NUM_DET-1:0] : '0;
    assign unused_bits = ^pwdata[23:16];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (cfg_wr) begin
            case (sel)
                SEL_ARM:    cfg.arm    <= pwdata[15:0];
                SEL_DISARM: cfg.disarm <= pwdata[15:0];
                SEL_SENS:   cfg.sens   <= '{ovr: pwdata[31:24],
                                            inv: pwdata[8 +: SV_W],
                                            val: pwdata[0 +: SV_W]};
                SEL_LOCK:   cfg.lock   <= pwdata[7:0];
                default:    ;
            endcase
        end
    end

    // a set arriving in the same cycle as a clear takes precedence
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_vec) | det_sync | force_vec;
    end

    always_comb begin
        prdata = '0;
        if (sec_ok) begin
            case (sel)
                SEL_ARM:    prdata = {16'h0, cfg.arm};
                SEL_DISARM: prdata = {16'h0, cfg.disarm};
                SEL_SENS:   prdata = {cfg.sens.ovr, 8'h0, cfg.sens.inv, cfg.sens.val};
                SEL_LOCK:   prdata = {24'h0, cfg.lock};
                SEL_STAT:   prdata = {{(DATA_W-NUM_DET){1'b0}}, status};
                default:    prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/glitch_ctl_eff.sv
module glitch_ctl_eff
    import glitch_ctl_pkg::*;
(
    input  cfg_t            cfg,
    input  logic            otp_arm,
    input  logic [SV_W-1:0] otp_sens,
    output logic            armed,
    output logic [SV_W-1:0] sens_eff
);
    logic forced, kept;
    logic ovr_on;

    assign forced = (cfg.arm != ARM_KEEP);
    assign kept   = otp_arm & (cfg.disarm != DISARM_KEY);
    assign armed  = forced | kept;
    assign ovr_on = (cfg.sens.ovr == OVR_KEY);

    for (genvar d = 0; d < NUM_DET; d++) begin : g_det
        logic [SENS_W-1:0] v, iv, dflt;
        assign v    = cfg.sens.val[d*SENS_W +: SENS_W];
        assign iv   = cfg.sens.inv[d*SENS_W +: SENS_W];
        assign dflt = otp_sens[d*SENS_W +: SENS_W];
        assign sens_eff[d*SENS_W +: SENS_W] = (ovr_on && (iv == ~v)) ? v : dflt;
    end
endmodule

// File: rtl/glitch_ctl.sv
module glitch_ctl
    import glitch_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    input  logic               psecure,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [NUM_DET-1:0] det_raw,
    input  logic               otp_arm,
    input  logic [SV_W-1:0]    otp_sens,
    output logic               armed,
    output logic [SV_W-1:0]    sens_eff,
    output logic               rst_req,
    output logic               rst_reason
);
    logic [NUM_DET-1:0] det_sync, status_w, force_w;
    cfg_t               cfg_w;
    logic               req_d;

    glitch_ctl_sync #(.WIDTH(NUM_DET)) sync_i (
        .clk(clk), .rst(rst), .async_in(det_raw), .sync_out(det_sync)
    );

    glitch_ctl_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .psecure(psecure), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .det_sync(det_sync),
        .cfg(cfg_w), .status(status_w), .force_vec(force_w)
    );

    glitch_ctl_eff eff_i (
        .cfg(cfg_w), .otp_arm(otp_arm), .otp_sens(otp_sens),
        .armed(armed), .sens_eff(sens_eff)
    );

    assign req_d = armed & (|(det_sync | force_w));

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req    <= 1'b0;
            rst_reason <= 1'b0;
        end else begin
            rst_req    <= req_d;
            rst_reason <= req_d & ~rst_req;
        end
    end
endmodule

// File: rtl/glitch_ctl_chk.sv
module glitch_ctl_chk
    import glitch_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic               psecure,
    input logic [ADDR_W-1:0]  paddr,
    input logic [DATA_W-1:0]  prdata,
    input logic               pslverr,
    input logic               armed,
    input logic               rst_req,
    input logic               rst_reason,
    input cfg_t               cfg_q,
    input logic [NUM_DET-1:0] status_q
);
    logic stat_wr;
    assign stat_wr = psel & penable & pwrite & psecure & (32'(paddr) == OFS_STAT);

    p_force_arm_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.arm != ARM_KEEP) |-> armed);

    p_lock_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.lock != 8'h0) |=> $stable(cfg_q));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    p_nonsecure_r12: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !psecure) |-> (pslverr && prdata == '0));

    p_req_needs_arm_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> $past(armed));

    p_reason_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        rst_reason |-> (rst_req && !$past(rst_req)));
endmodule

bind glitch_ctl glitch_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .psecure(psecure), .paddr(paddr), .prdata(prdata), .pslverr(pslverr),
    .armed(armed), .rst_req(rst_req), .rst_reason(rst_reason),
    .cfg_q(cfg_w), .status_q(status_w)
);

// File: tb/glitch_ctl_tb_top.sv
module glitch_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 0, penable = 0, pwrite = 0, psecure = 0;
    logic [7:0]  paddr = 0;
    logic [31:0] pwdata = 0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [3:0]  det_raw = 0;
    logic        otp_arm = 0;
    logic [7:0]  otp_sens = 0;
    logic        armed;
    logic [7:0]  sens_eff;
    logic        rst_req, rst_reason;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    glitch_ctl #(.ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .psecure(psecure), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .det_raw(det_raw), .otp_arm(otp_arm),
        .otp_sens(otp_sens), .armed(armed), .sens_eff(sens_eff),
        .rst_req(rst_req), .rst_reason(rst_reason)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic last_err;
    logic last_rdy;

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d, input logic sec);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; psecure = sec;
        @(negedge clk);
        penable = 1;
        #1 last_err = pslverr; last_rdy = pready;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0; psecure = 0;
    endtask

    task automatic apb_rd(input logic [7:0] a, input logic sec, output logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 0; paddr = a; psecure = sec;
        @(negedge clk);
        penable = 1;
        #1 d = prdata; last_err = pslverr; last_rdy = pready;
        @(negedge clk);
        psel = 0; penable = 0; psecure = 0;
    endtask

    function automatic logic [7:0] exp_sens(input logic [7:0] key, input logic [7:0] v,
                                            input logic [7:0] iv, input logic [7:0] otp);
        logic [7:0] r;
        for (int d = 0; d < 4; d++) begin
            if (key == 8'hDE && iv[2*d +: 2] == ~v[2*d +: 2]) r[2*d +: 2] = v[2*d +: 2];
            else r[2*d +: 2] = otp[2*d +: 2];
        end
        return r;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        otp_arm = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        #1 chk("R1 armed follows otp", {31'h0, armed}, 32'h1);
        chk("R1 rst_req low", {31'h0, rst_req}, 32'h0);
        apb_rd(8'h00, 1, rd); chk("R1 arm word", rd, 32'h5BAD);
        apb_rd(8'h04, 1, rd); chk("R1 disarm word", rd, 32'h0);
        apb_rd(8'h08, 1, rd); chk("R1 sens word", rd, 32'h0);
        apb_rd(8'h0C, 1, rd); chk("R1 lock byte", rd, 32'h0);
        apb_rd(8'h10, 1, rd); chk("R1 flags", rd, 32'h0);

        // R2 / R3: arm sweep
        begin
            logic [15:0] arms [5] = '{16'h5BAD, 16'h0000, 16'h5BAC, 16'hFFFF, 16'hDBAD};
            logic [15:0] dis  [4] = '{16'h0000, 16'hDCAF, 16'hDCAE, 16'h5BAD};
            for (int o = 0; o < 2; o++) begin
                for (int i = 0; i < 5; i++) begin
                    for (int j = 0; j < 4; j++) begin
                        otp_arm = o[0];
                        apb_wr(8'h00, {16'hFFFF, arms[i]}, 1);
                        apb_wr(8'h04, {16'h1234, dis[j]}, 1);
                        #1;
                        if (arms[i] != 16'h5BAD)
                            chk("R2 forced arm", {31'h0, armed}, 32'h1);
                        else
                            chk("R3 otp arm with disarm", {31'h0, armed},
                                {31'h0, o[0] & (dis[j] != 16'hDCAF)});
                    end
                end
            end
            apb_rd(8'h04, 1, rd); chk("R3 disarm readback", rd, 32'h5BAD);
        end

        // R4 / R5: sensitivity sweep
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] vb, ib, ob, masks [4];
                masks = '{8'h00, 8'h01, 8'h30, 8'hFF};
                vb = v[7:0];
                ib = ~vb ^ masks[k];
                ob = vb ^ 8'hA5 ^ 8'(k);
                otp_sens = ob;
                apb_wr(8'h08, {8'hDE, 8'hFF, ib, vb}, 1);
                #1 chk("R5 inverse-checked override", {24'h0, sens_eff},
                       {24'h0, exp_sens(8'hDE, vb, ib, ob)});
            end
        end
        apb_rd(8'h08, 1, rd);
        chk("R4 unused bits read zero", rd, {8'hDE, 8'h00, ~8'hFF ^ 8'hFF, 8'hFF});
        begin
            logic [7:0] keys [3] = '{8'hDF, 8'h00, 8'h5E};
            for (int i = 0; i < 3; i++) begin
                otp_sens = 8'h1B + 8'(i);
                apb_wr(8'h08, {keys[i], 8'h00, 8'hC6, 8'h39}, 1);
                #1 chk("R4 wrong key uses otp", {24'h0, sens_eff}, {24'h0, 8'h1B + 8'(i)});
            end
        end

        // R7 / R10 / R11: synchronizer latency with arming forced
        otp_arm = 0;
        apb_wr(8'h00, 32'h0, 1);
        apb_wr(8'h10, 32'hF, 1);
        det_raw = 4'b0101;
        @(negedge clk); chk("R7 not after edge 1", {31'h0, rst_req}, 32'h0);
        @(negedge clk); chk("R7 not after edge 2", {31'h0, rst_req}, 32'h0);
        @(negedge clk); chk("R10 request after edge 3", {31'h0, rst_req}, 32'h1);
        chk("R11 reason pulse high", {31'h0, rst_reason}, 32'h1);
        @(negedge clk); chk("R10 request held", {31'h0, rst_req}, 32'h1);
        chk("R11 reason pulse one cycle", {31'h0, rst_reason}, 32'h0);
        apb_rd(8'h10, 1, rd); chk("R7 flags set", rd, 32'h5);
        det_raw = 4'b0000;
        repeat (3) @(negedge clk);
        apb_rd(8'h10, 1, rd); chk("R7 flags sticky", rd, 32'h5);
        chk("R10 request drops", {31'h0, rst_req}, 32'h0);
        apb_wr(8'h10, 32'h4, 1);
        apb_rd(8'h10, 1, rd); chk("R8 clear one bit", rd, 32'h1);
        apb_wr(8'h10, 32'h1, 1);
        apb_rd(8'h10, 1, rd); chk("R8 clear rest", rd, 32'h0);

        // R8: set wins over clear
        det_raw = 4'b0001;
        repeat (3) @(negedge clk);
        apb_wr(8'h10, 32'h1, 1);
        apb_rd(8'h10, 1, rd); chk("R8 set wins", rd, 32'h1);

        // R10: disarmed trigger raises no request
        apb_wr(8'h00, 32'h5BAD, 1);
        repeat (2) @(negedge clk);
        chk("R10 no request when disarmed", {31'h0, rst_req}, 32'h0);
        det_raw = 4'b0000;
        repeat (3) @(negedge clk);
        apb_wr(8'h10, 32'hF, 1);

        // R9: inject, disarmed then armed
        apb_wr(8'h14, 32'h8, 1);
        chk("R9 inject disarmed no request", {31'h0, rst_req}, 32'h0);
        apb_rd(8'h10, 1, rd); chk("R9 inject sets flag", rd, 32'h8);
        apb_rd(8'h14, 1, rd); chk("R9 inject reads zero", rd, 32'h0);
        apb_wr(8'h00, 32'h0001, 1);
        apb_wr(8'h14, 32'h2, 1);
        chk("R10 inject armed request", {31'h0, rst_req}, 32'h1);
        chk("R11 inject reason", {31'h0, rst_reason}, 32'h1);
        apb_rd(8'h10, 1, rd); chk("R9 inject flags", rd, 32'hA);
        apb_wr(8'h00, 32'h5BAD, 1);
        apb_wr(8'h10, 32'hF, 1);

        // R12: non-secure access
        apb_wr(8'h00, 32'h0, 0);
        chk("R12 write error", {31'h0, last_err}, 32'h1);
        #1 chk("R12 write no effect", {31'h0, armed}, 32'h0);
        apb_rd(8'h00, 0, rd);
        chk("R12 read zero", rd, 32'h0);
        chk("R12 read error", {31'h0, last_err}, 32'h1);
        apb_wr(8'h14, 32'hF, 0);
        apb_rd(8'h10, 1, rd); chk("R12 inject blocked", rd, 32'h0);

        // R13: unmapped
        apb_rd(8'h18, 1, rd);
        chk("R13 unmapped zero", rd, 32'h0);
        chk("R13 unmapped no error", {31'h0, last_err}, 32'h0);
        chk("R13 ready high", {31'h0, last_rdy}, 32'h1);

        // R6: lock
        apb_wr(8'h08, 32'h0000_0000, 1);
        apb_wr(8'h0C, 32'h80, 1);
        apb_rd(8'h0C, 1, rd); chk("R6 lock set", rd, 32'h80);
        apb_wr(8'h00, 32'h0, 1);
        #1 chk("R6 arm frozen", {31'h0, armed}, 32'h0);
        apb_rd(8'h00, 1, rd); chk("R6 arm word frozen", rd, 32'h5BAD);
        apb_wr(8'h04, 32'hDCAF, 1);
        apb_rd(8'h04, 1, rd); chk("R6 disarm frozen", rd, 32'h5BAD);
        apb_wr(8'h08, 32'hDE00_C639, 1);
        apb_rd(8'h08, 1, rd); chk("R6 sens frozen", rd, 32'h0);
        apb_wr(8'h0C, 32'h0, 1);
        apb_rd(8'h0C, 1, rd); chk("R6 lock cannot clear", rd, 32'h80);
        apb_wr(8'h14, 32'h2, 1);
        apb_rd(8'h10, 1, rd); chk("R6 flags still writable", rd, 32'h2);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule